// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a virtual address into a physical address through a small table of segments. The upper bits of the virtual address select one table entry, and the lower bits are an offset inside that segment. Each entry holds a valid flag, a physical base and a limit. When the entry is valid and the offset lies below the limit, the physical address is the base plus the offset. When the entry is invalid, or the offset reaches the limit, the block reports a protection fault with a cause code instead.

Software or a controlling sequencer loads entries through a configuration write port, one entry per cycle. Lookups are registered. A request presented on one clock edge yields its result on the outputs after that edge, and the result holds until the next edge. With a single segment in use, the block behaves as one relocation register and one bound register for a whole program.

Top module: `segx_translator`

## Requirements
- R1: Reset clears every table entry to invalid, deasserts `rsp_ok` and `rsp_fault`, and sets `rsp_cause` to 0 and `rsp_paddr` to 0.
- R2: The segment index is the upper `SEG_BITS` bits of `req_vaddr`, and the offset is the lower `OFF_BITS` bits.
- R3: A request to a valid entry whose offset is less than that entry's limit asserts `rsp_ok`. `rsp_paddr` then equals base plus offset, modulo 2^`PA_BITS`.
- R4: A request to a valid entry whose offset is greater than or equal to its limit asserts `rsp_fault` with `rsp_cause` = 2'b01 (bound violation), and `rsp_paddr` = 0.
- R5: A request to an invalid entry asserts `rsp_fault` with `rsp_cause` = 2'b10 (missing segment), whatever the offset and limit are.
- R6: A valid entry with a limit of 0 faults every offset with cause 2'b01. A limit of 2^`OFF_BITS` admits every offset.
- R7: The result of a request appears one clock after it is presented. A cycle with `req_valid` low produces neither `rsp_ok` nor `rsp_fault` on the following cycle.
- R8: `rsp_ok` and `rsp_fault` are never high together. `rsp_cause` is 0 whenever `rsp_fault` is low, and `rsp_paddr` is 0 whenever `rsp_ok` is low.
- R9: A table write takes effect for lookups presented from the cycle after the write. A lookup presented in the same cycle as the write uses the old entry.
- R10: A table write with `cfg_valid` low makes the entry invalid, so later lookups to it fault with cause 2'b10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | SEG_BITS | Entry being written |
| cfg_valid | input | 1 | Valid flag written to the entry |
| cfg_base | input | PA_BITS | Physical base written to the entry |
| cfg_limit | input | OFF_BITS+1 | Segment length written to the entry |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | SEG_BITS+OFF_BITS | Virtual address: segment index and offset |
| rsp_ok | output | 1 | Translated address is valid |
| rsp_paddr | output | PA_BITS | Translated physical address |
| rsp_fault | output | 1 | Protection fault |
| rsp_cause | output | 2 | Fault cause: 01 bound, 10 missing segment |

## Verification
A corrupted entry, such as a stuck valid flag or a wrong base or limit bit, shows up on the first lookup to that segment. It appears one clock later as a wrong physical address, a fault where a hit was due, or the wrong cause code. The offset comparison can be off by one at the bound, so the bench probes the offsets just below and exactly at each limit. It also probes the zero and full-range limits. A write that lands a cycle early or late is seen by placing a lookup in the same cycle as the write, and another lookup right after it.

// File: rtl/segx_pkg.sv
package segx_pkg;

    localparam int CAUSE_W = 2;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_NONE    = 2'b00,
        CAUSE_BOUND   = 2'b01,
        CAUSE_MISSING = 2'b10
    } seg_cause_e;

    typedef struct packed {
        logic       hit;
        seg_cause_e cause;
    } seg_verdict_t;

endpackage

// File: rtl/segx_table.sv
module segx_table #(
    parameter int SEG_BITS = 2,
    parameter int PA_BITS  = 12,
    parameter int LIM_BITS = 9
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [SEG_BITS-1:0] wr_idx,
    input  logic                wr_valid,
    input  logic [PA_BITS-1:0]  wr_base,
    input  logic [LIM_BITS-1:0] wr_limit,
    input  logic [SEG_BITS-1:0] rd_idx,
    output logic                rd_valid,
    output logic [PA_BITS-1:0]  rd_base,
    output logic [LIM_BITS-1:0] rd_limit
);
    localparam int DEPTH = 1 << SEG_BITS;

    logic                ent_valid [DEPTH];
    logic [PA_BITS-1:0]  ent_base  [DEPTH];
    logic [LIM_BITS-1:0] ent_limit [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_valid[g] <= 1'b0;
                ent_base[g]  <= '0;
                ent_limit[g] <= '0;
            end else if (wr_en && (wr_idx == SEG_BITS'(g))) begin
                ent_valid[g] <= wr_valid;
                ent_base[g]  <= wr_base;
                ent_limit[g] <= wr_limit;
            end
        end
    end

    assign rd_valid = ent_valid[rd_idx];
    assign rd_base  = ent_base[rd_idx];
    assign rd_limit = ent_limit[rd_idx];
endmodule

// File: rtl/segx_check.sv
module segx_check
    import segx_pkg::*;
#(
    parameter int OFF_BITS = 8,
    parameter int PA_BITS  = 12,
    parameter int LIM_BITS = 9
) (
    input  logic                ent_valid,
    input  logic [PA_BITS-1:0]  ent_base,
    input  logic [LIM_BITS-1:0] ent_limit,
    input  logic [OFF_BITS-1:0] offset,
    output seg_verdict_t        verdict,
    output logic [PA_BITS-1:0]  paddr
);
    logic below;

    assign below = LIM_BITS'(offset) < ent_limit;

    always_comb begin
        if (!ent_valid) begin
            verdict = '{hit: 1'b0, cause: CAUSE_MISSING};
        end else if (!below) begin
            verdict = '{hit: 1'b0, cause: CAUSE_BOUND};
        end else begin
            verdict = '{hit: 1'b1, cause: CAUSE_NONE};
        end
    end

    assign paddr = ent_base + PA_BITS'(offset);
endmodule

// File: rtl/segx_translator.sv
module segx_translator
    import segx_pkg::*;
#(
    parameter int SEG_BITS = 2,
    parameter int OFF_BITS = 8,
    parameter int PA_BITS  = 12
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cfg_we,
    input  logic [SEG_BITS-1:0]          cfg_idx,
    input  logic                         cfg_valid,
    input  logic [PA_BITS-1:0]           cfg_base,
    input  logic [OFF_BITS:0]            cfg_limit,
    input  logic                         req_valid,
    input  logic [SEG_BITS+OFF_BITS-1:0] req_vaddr,
    output logic                         rsp_ok,
    output logic [PA_BITS-1:0]           rsp_paddr,
    output logic                         rsp_fault,
    output logic [CAUSE_W-1:0]           rsp_cause
);
    localparam int VA_BITS  = SEG_BITS + OFF_BITS;
    localparam int LIM_BITS = OFF_BITS + 1;

    logic [SEG_BITS-1:0] seg_sel;
    logic [OFF_BITS-1:0] off_sel;
    logic                sel_valid;
    logic [PA_BITS-1:0]  sel_base;
    logic [LIM_BITS-1:0] sel_limit;
    seg_verdict_t        verdict;
    logic [PA_BITS-1:0]  pa_next;

    assign seg_sel = req_vaddr[VA_BITS-1 -: SEG_BITS];
    assign off_sel = req_vaddr[OFF_BITS-1:0];

    segx_table #(
        .SEG_BITS (SEG_BITS),
        .PA_BITS  (PA_BITS),
        .LIM_BITS (LIM_BITS)
    ) u_table (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_we),
        .wr_idx   (cfg_idx),
        .wr_valid (cfg_valid),
        .wr_base  (cfg_base),
        .wr_limit (cfg_limit),
        .rd_idx   (seg_sel),
        .rd_valid (sel_valid),
        .rd_base  (sel_base),
        .rd_limit (sel_limit)
    );

    segx_check #(
        .OFF_BITS (OFF_BITS),
        .PA_BITS  (PA_BITS),
        .LIM_BITS (LIM_BITS)
    ) u_check (
        .ent_valid (sel_valid),
        .ent_base  (sel_base),
        .ent_limit (sel_limit),
        .offset    (off_sel),
        .verdict   (verdict),
        .paddr     (pa_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_ok    <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_cause <= CAUSE_NONE;
            rsp_paddr <= '0;
        end else begin
            rsp_ok    <= req_valid && verdict.hit;
            rsp_fault <= req_valid && !verdict.hit;
            rsp_cause <= req_valid ? verdict.cause : CAUSE_NONE;
            rsp_paddr <= (req_valid && verdict.hit) ? pa_next : '0;
        end
    end
endmodule

// File: rtl/segx_chk.sv
module segx_chk
    import segx_pkg::*;
#(
    parameter int PA_BITS = 12
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               rsp_ok,
    input logic [PA_BITS-1:0] rsp_paddr,
    input logic               rsp_fault,
    input logic [CAUSE_W-1:0] rsp_cause
);
    // R8
    ok_fault_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(rsp_ok && rsp_fault));

    // R8
    cause_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !rsp_fault |-> rsp_cause == CAUSE_NONE);

    // R4
    fault_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> (rsp_cause == CAUSE_BOUND || rsp_cause == CAUSE_MISSING));

    // R8
    paddr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !rsp_ok |-> rsp_paddr == '0);

    // R7
    answer_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (rsp_ok || rsp_fault));

    // R7
    idle_follows_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !(rsp_ok || rsp_fault));

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!rsp_ok && !rsp_fault && rsp_cause == CAUSE_NONE));
endmodule

bind segx_translator segx_chk #(.PA_BITS(PA_BITS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .rsp_ok    (rsp_ok),
    .rsp_paddr (rsp_paddr),
    .rsp_fault (rsp_fault),
    .rsp_cause (rsp_cause)
);

// File: tb/tb_segx_translator.sv
`timescale 1ns/1ps
module tb_segx_translator;
    localparam int SB = 2;
    localparam int OB = 8;
    localparam int PB = 12;

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_we;
    logic [SB-1:0] cfg_idx;
    logic          cfg_valid;
    logic [PB-1:0] cfg_base;
    logic [OB:0]   cfg_limit;
    logic          req_valid;
    logic [SB+OB-1:0] req_vaddr;
    logic          rsp_ok;
    logic [PB-1:0] rsp_paddr;
    logic          rsp_fault;
    logic [1:0]    rsp_cause;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    segx_translator #(.SEG_BITS(SB), .OFF_BITS(OB), .PA_BITS(PB)) dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_valid(cfg_valid), .cfg_base(cfg_base), .cfg_limit(cfg_limit),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .rsp_ok(rsp_ok),
        .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause)
    );

    // vector: {seg[2], off[8], ok[1], cause[2], paddr[12]}
    localparam int NV = 10;
    localparam logic [24:0] VEC [NV] = '{
        {2'd0, 8'h00, 1'b1, 2'b00, 12'h100},
        {2'd0, 8'h3F, 1'b1, 2'b00, 12'h13F},
        {2'd0, 8'h40, 1'b0, 2'b01, 12'h000},
        {2'd0, 8'hFF, 1'b0, 2'b01, 12'h000},
        {2'd1, 8'h7F, 1'b1, 2'b00, 12'hFFF},
        {2'd1, 8'hA0, 1'b1, 2'b00, 12'h020},
        {2'd1, 8'hFF, 1'b1, 2'b00, 12'h07F},
        {2'd2, 8'h00, 1'b0, 2'b01, 12'h000},
        {2'd3, 8'h00, 1'b0, 2'b10, 12'h000},
        {2'd3, 8'h10, 1'b0, 2'b10, 12'h000}
    };

    task automatic check(input string tag, input logic eok, input logic [1:0] ecause,
                         input logic [PB-1:0] epa);
        logic efault;
        efault = (ecause != 2'b00);
        n_checks++;
        if (rsp_ok !== eok || rsp_fault !== efault || rsp_cause !== ecause || rsp_paddr !== epa) begin
            n_fail++;
            $display("FAIL %s: got ok=%0b fault=%0b cause=%0b pa=%h, expected ok=%0b fault=%0b cause=%0b pa=%h",
                     tag, rsp_ok, rsp_fault, rsp_cause, rsp_paddr, eok, efault, ecause, epa);
        end
    endtask

    task automatic write_ent(input logic [SB-1:0] idx, input logic v,
                             input logic [PB-1:0] b, input logic [OB:0] l);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_valid = v; cfg_base = b; cfg_limit = l;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic lookup(input logic [SB-1:0] s, input logic [OB-1:0] o);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = {s, o};
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_idx = '0; cfg_valid = 1'b0;
        cfg_base = '0; cfg_limit = '0; req_valid = 1'b0; req_vaddr = '0;
        repeat (3) @(negedge clk);
        check("R1 reset outputs", 1'b0, 2'b00, '0);
        rst = 1'b0;

        // R1: table empty after reset
        lookup(2'd1, 8'h00);
        check("R1 entry invalid after reset", 1'b0, 2'b10, '0);

        write_ent(2'd0, 1'b1, 12'h100, 9'h040);
        write_ent(2'd1, 1'b1, 12'hF80, 9'h100); // R6 full-range limit
        write_ent(2'd2, 1'b1, 12'h200, 9'h000); // R6 zero limit

        for (int i = 0; i < NV; i++) begin
            lookup(VEC[i][24:23], VEC[i][22:15]);
            if (VEC[i][14])
                check($sformatf("R2/R3 vector %0d", i), VEC[i][14], VEC[i][13:12], VEC[i][11:0]);
            else if (VEC[i][13:12] == 2'b01)
                check($sformatf("R4/R6 vector %0d", i), VEC[i][14], VEC[i][13:12], VEC[i][11:0]);
            else
                check($sformatf("R5 vector %0d", i), VEC[i][14], VEC[i][13:12], VEC[i][11:0]);
        end

        // R7: idle cycle after a request
        @(negedge clk);
        check("R7 idle gives no answer", 1'b0, 2'b00, '0);

        // R7: back-to-back requests, one result per cycle
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = {2'd0, 8'h05};
        @(negedge clk);
        check("R7 first of pair", 1'b1, 2'b00, 12'h105);
        req_vaddr = {2'd0, 8'h41};
        @(negedge clk);
        check("R7 second of pair", 1'b0, 2'b01, '0);
        req_valid = 1'b0;

        // R9: lookup in same cycle as write sees old entry
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 2'd3; cfg_valid = 1'b1; cfg_base = 12'h300; cfg_limit = 9'h010;
        req_valid = 1'b1; req_vaddr = {2'd3, 8'h05};
        @(negedge clk);
        cfg_we = 1'b0;
        check("R9 same-cycle lookup uses old entry", 1'b0, 2'b10, '0);
        @(negedge clk);
        req_valid = 1'b0;
        check("R9 next-cycle lookup uses new entry", 1'b1, 2'b00, 12'h305);

        // R10: invalidate entry 0
        write_ent(2'd0, 1'b0, 12'h100, 9'h040);
        lookup(2'd0, 8'h00);
        check("R10 invalidated entry faults", 1'b0, 2'b10, '0);

        // R1: reset mid-run empties table
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        lookup(2'd1, 8'h00);
        check("R1 reset clears loaded entry", 1'b0, 2'b10, '0);

        finish_run();
    end
endmodule